// File: doc/BRIEF.md
# Phase Detector with Lock Monitor

This block sits between the two programmable dividers of a frequency synthesizer and the loop filter. It takes single-cycle strobes from the reference divider and from the comparison divider, all synchronous to the oscillator clock. It keeps one lead flop per input, in the usual phase-frequency detector arrangement. From these flops it drives an up/down pulse pair for an external charge pump. It also drives an internal charge-pump output, modelled as a level plus an enable, where a low enable stands for high impedance.

The phase error is the number of oscillator cycles during which exactly one lead flop is set. The two flops clear together one cycle after both are set. That one-cycle overlap is the short pulse pair that keeps the detector out of its dead zone at zero error. A lock judge watches the error of every comparison and keeps a lock flag. A monitor pin carries either the lock flag or the active lead flop.

A polarity input reverses the sense of the outputs. A forced-off input floats the charge pump. A power-down input clears the detector and holds lock high.

Top module: `phase_lock_detector`

## Requirements
- R1: While rst_n is low at a clock edge, every output is low after that edge: up_o, dn_o, cp_en, cp_drive, lock_o, and also mon_o when mon_sel is 0.
- R2: With polarity at 1, a reference strobe that arrives first sets up_o and leaves dn_o low, and the charge pump is enabled with cp_drive at 1. A comparison strobe that arrives first sets dn_o, and the charge pump drives 0. Each output reacts in the cycle after the strobe.
- R3: With polarity at 0, up_o and dn_o swap roles, so up_o follows the comparison flop. The driven charge-pump level is also inverted: 0 when the reference leads and 1 when the comparison leads.
- R4: The cycle after both flops are set, up_o and dn_o are both high for exactly one cycle and cp_en is 0. This holds when the two strobes arrive together and when they arrive apart. Both outputs are low in the cycle that follows.
- R5: While force_z_n is 0, cp_en and cp_drive stay 0. up_o and dn_o are unaffected.
- R6: The phase error of a comparison is the number of cycles between the two strobes. An error of UNLOCK_CYC (8) or more drops lock_o and restarts the good-comparison count. This takes priority over R7.
- R7: lock_o rises after GOOD_RUNS (3) consecutive comparisons whose error is at most LOCK_CYC (16) and below UNLOCK_CYC. Two such comparisons are not enough.
- R8: While pwr_on is 0, lock_o is held at 1. The lead flops, up_o, dn_o and cp_en are 0, and strobes are ignored. After pwr_on returns to 1, lock_o stays 1 until an unlock event of the kind in R6.
- R9: With mon_sel at 0, mon_o equals lock_o. With mon_sel at 1, mon_o shows the reference flop when polarity is 1 and the comparison flop when polarity is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; every count is in its cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_pulse | input | 1 | One-cycle strobe from the reference divider |
| cmp_pulse | input | 1 | One-cycle strobe from the comparison divider |
| polarity | input | 1 | 1: reference lead drives the pump high; 0: reversed |
| force_z_n | input | 1 | 0 forces the charge pump to high impedance |
| pwr_on | input | 1 | 1: normal operation; 0: power-down |
| mon_sel | input | 1 | 0: mon_o carries lock; 1: mon_o carries the active lead flop |
| up_o | output | 1 | Pump-up pulse |
| dn_o | output | 1 | Pump-down pulse |
| cp_en | output | 1 | Charge-pump drive enable; 0 means high impedance |
| cp_drive | output | 1 | Charge-pump level while cp_en is 1, else 0 |
| lock_o | output | 1 | Lock flag |
| mon_o | output | 1 | Shared monitor output |

## Verification
Two events can fall in the same cycle. The first is the evaluation of a comparison, which happens in the one cycle where both flops are set and the flops are clearing. The second is the live unlock that the error counter raises once it reaches the threshold. Random comparisons with errors from 0 to 12 cycles, on either side of the 8-cycle threshold, make both happen in the same cycle. The bench judges the outcome by the lock flag a few cycles after each comparison, against a bench model of the good-comparison count. Power-down dips are dropped between comparisons to check that the held lock and the restarted count survive the return to normal operation.

// File: rtl/pd_pkg.sv
// Shared types for the phase detector: which lead flops are currently set.
package pd_pkg;
    localparam int CH_REF = 0;
    localparam int CH_CMP = 1;
    localparam int N_CH   = 2;

    typedef enum logic [1:0] {
        LEAD_NONE = 2'b00,
        LEAD_REF  = 2'b01,
        LEAD_CMP  = 2'b10,
        LEAD_BOTH = 2'b11
    } lead_e;
endpackage

// File: rtl/pd_edge_latch.sv
// Two lead flops of the phase-frequency detector. A strobe sets its flop;
// once both are set they clear together on the next edge, giving a
// one-cycle overlap. Assumes strobes are one cycle wide and synchronous.
module pd_edge_latch
    import pd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  active,
    input  logic  ref_pulse,
    input  logic  cmp_pulse,
    output lead_e lead
);
    logic [N_CH-1:0] strobe;
    logic [N_CH-1:0] q;
    logic            both;

    assign strobe[CH_REF] = ref_pulse;
    assign strobe[CH_CMP] = cmp_pulse;
    assign both           = &q;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_lead
        // Set on strobe, release after overlap, clear in power-down.
        always_ff @(posedge clk) begin
            if (!rst_n || !active) q[ch] <= 1'b0;
            else                   q[ch] <= (q[ch] & ~both) | strobe[ch];
        end
    end

    assign lead = lead_e'(q);

    assert_overlap_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lead == LEAD_BOTH && !ref_pulse && !cmp_pulse) |=> (lead == LEAD_NONE));
endmodule

// File: rtl/pd_error_meter.sv
// Counts cycles with exactly one lead flop set (the phase error), flags an
// evaluation in the overlap cycle and raises err_big once the count reaches
// the unlock threshold. Saturates just above the larger threshold.
module pd_error_meter
    import pd_pkg::*;
#(
    parameter int UNLOCK_CYC = 8,
    parameter int LOCK_CYC   = 16,
    parameter int ERR_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  lead_e            lead,
    output logic [ERR_W-1:0] err_cnt,
    output logic             eval,
    output logic             err_big
);
    localparam int ERR_SAT = ((UNLOCK_CYC > LOCK_CYC) ? UNLOCK_CYC : LOCK_CYC) + 1;

    logic single;
    assign single  = (lead == LEAD_REF) || (lead == LEAD_CMP);
    assign eval    = (lead == LEAD_BOTH);
    assign err_big = (err_cnt >= ERR_W'(UNLOCK_CYC));

    // Error counter: grow while one side leads, restart after evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)                    err_cnt <= '0;
        else if (eval)                            err_cnt <= '0;
        else if (single && err_cnt != ERR_W'(ERR_SAT)) err_cnt <= err_cnt + 1'b1;
    end

    assert_err_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> (err_cnt == '0));
endmodule

// File: rtl/pd_lock_judge.sv
// Lock flag with a run counter of good comparisons. An unlock event clears
// both; power-down forces lock high and restarts the run count.
module pd_lock_judge #(
    parameter int LOCK_CYC  = 16,
    parameter int GOOD_RUNS = 3,
    parameter int ERR_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             eval,
    input  logic             err_big,
    input  logic [ERR_W-1:0] err_cnt,
    output logic             lock
);
    localparam int RUN_W = $clog2(GOOD_RUNS + 1);

    logic [RUN_W-1:0] runs;

    // Lock decision: power-down, then unlock, then evaluated comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= 1'b0;
            runs <= '0;
        end else if (!active) begin
            lock <= 1'b1;
            runs <= '0;
        end else if (err_big) begin
            lock <= 1'b0;
            runs <= '0;
        end else if (eval) begin
            if (err_cnt <= ERR_W'(LOCK_CYC)) begin
                if (runs >= RUN_W'(GOOD_RUNS - 1)) lock <= 1'b1;
                if (runs != RUN_W'(GOOD_RUNS))     runs <= runs + 1'b1;
            end else begin
                runs <= '0;
            end
        end
    end

    assert_lock_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lock) && $past(rst_n)) |-> $past(err_big));
    assert_lock_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock) && $past(rst_n)) |-> ($past(eval) || !$past(active)));
    assert_powerdown_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> lock);
endmodule

// File: rtl/pd_output_map.sv
// Pure logic from lead flops to pins: polarity swap, charge-pump enable and
// level, forced high impedance and the monitor mux.
module pd_output_map
    import pd_pkg::*;
(
    input  lead_e lead,
    input  logic  active,
    input  logic  polarity,
    input  logic  force_z_n,
    input  logic  mon_sel,
    input  logic  lock,
    output logic  up_o,
    output logic  dn_o,
    output logic  cp_en,
    output logic  cp_drive,
    output logic  mon_o
);
    logic [1:0] lv;
    logic       ref_on;
    logic       cmp_on;

    // Decode and map the lead state onto the output pins.
    always_comb begin
        lv       = lead;
        ref_on   = active & lv[CH_REF];
        cmp_on   = active & lv[CH_CMP];
        up_o     = polarity ? ref_on : cmp_on;
        dn_o     = polarity ? cmp_on : ref_on;
        cp_en    = active & force_z_n & (ref_on ^ cmp_on);
        cp_drive = cp_en & (ref_on ? polarity : ~polarity);
        mon_o    = mon_sel ? (polarity ? ref_on : cmp_on) : lock;
    end
endmodule

// File: rtl/phase_lock_detector.sv
// Top of the phase detector: lead flops, error meter, lock judge, output map.
// Assumes both strobes come from dividers clocked by clk.
module phase_lock_detector #(
    parameter int UNLOCK_CYC = 8,
    parameter int LOCK_CYC   = 16,
    parameter int GOOD_RUNS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic cmp_pulse,
    input  logic polarity,
    input  logic force_z_n,
    input  logic pwr_on,
    input  logic mon_sel,
    output logic up_o,
    output logic dn_o,
    output logic cp_en,
    output logic cp_drive,
    output logic lock_o,
    output logic mon_o
);
    import pd_pkg::*;

    localparam int ERR_SAT = ((UNLOCK_CYC > LOCK_CYC) ? UNLOCK_CYC : LOCK_CYC) + 1;
    localparam int ERR_W   = $clog2(ERR_SAT + 1);

    lead_e            lead;
    logic [ERR_W-1:0] err_cnt;
    logic             eval;
    logic             err_big;

    pd_edge_latch u_latch (
        .clk(clk), .rst_n(rst_n), .active(pwr_on),
        .ref_pulse(ref_pulse), .cmp_pulse(cmp_pulse), .lead(lead)
    );

    pd_error_meter #(.UNLOCK_CYC(UNLOCK_CYC), .LOCK_CYC(LOCK_CYC), .ERR_W(ERR_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .active(pwr_on), .lead(lead),
        .err_cnt(err_cnt), .eval(eval), .err_big(err_big)
    );

    pd_lock_judge #(.LOCK_CYC(LOCK_CYC), .GOOD_RUNS(GOOD_RUNS), .ERR_W(ERR_W)) u_judge (
        .clk(clk), .rst_n(rst_n), .active(pwr_on), .eval(eval),
        .err_big(err_big), .err_cnt(err_cnt), .lock(lock_o)
    );

    pd_output_map u_map (
        .lead(lead), .active(pwr_on), .polarity(polarity), .force_z_n(force_z_n),
        .mon_sel(mon_sel), .lock(lock_o), .up_o(up_o), .dn_o(dn_o),
        .cp_en(cp_en), .cp_drive(cp_drive), .mon_o(mon_o)
    );

    assert_single_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cp_en |-> (up_o ^ dn_o));
    assert_overlap_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o && dn_o) |-> !cp_en);
    assert_overlap_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o && dn_o && !ref_pulse && !cmp_pulse) |=> (!up_o && !dn_o));
endmodule

// File: tb/phase_lock_detector_tb.sv
module phase_lock_detector_tb;
    localparam int UNLOCK = 8;
    localparam int LOCKC  = 16;
    localparam int RUNS   = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, ref_pulse, cmp_pulse, polarity, force_z_n, pwr_on, mon_sel;
    logic up_o, dn_o, cp_en, cp_drive, lock_o, mon_o;

    int n_chk = 0;
    int n_bad = 0;
    int exp_runs = 0;
    logic exp_lock = 1'b0;

    phase_lock_detector u_dut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .cmp_pulse(cmp_pulse),
        .polarity(polarity), .force_z_n(force_z_n), .pwr_on(pwr_on), .mon_sel(mon_sel),
        .up_o(up_o), .dn_o(dn_o), .cp_en(cp_en), .cp_drive(cp_drive),
        .lock_o(lock_o), .mon_o(mon_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, expv);
        end
    endtask

    // Bench model of the lock judge after one comparison of error n.
    function automatic void model_cmp(input int n);
        if (n >= UNLOCK) begin
            exp_lock = 1'b0;
            exp_runs = 0;
        end else if (n <= LOCKC) begin
            exp_runs = (exp_runs < RUNS) ? exp_runs + 1 : RUNS;
            if (exp_runs >= RUNS) exp_lock = 1'b1;
        end else begin
            exp_runs = 0;
        end
    endfunction

    // One comparison: leader strobe, n cycles, lagger strobe; entered at a negedge.
    task automatic run_cmp(input bit ref_first, input int n);
        string rq;
        rq = polarity ? "R2" : "R3";
        if (n == 0) begin
            ref_pulse = 1'b1; cmp_pulse = 1'b1;
            @(negedge clk);
            ref_pulse = 1'b0; cmp_pulse = 1'b0;
        end else begin
            if (ref_first) ref_pulse = 1'b1; else cmp_pulse = 1'b1;
            @(negedge clk);
            ref_pulse = 1'b0; cmp_pulse = 1'b0;
            chk(rq, "up_o lead", up_o, polarity ? ref_first : !ref_first);
            chk(rq, "dn_o lead", dn_o, polarity ? !ref_first : ref_first);
            chk(force_z_n ? rq : "R5", "cp_en lead", cp_en, force_z_n);
            chk(force_z_n ? rq : "R5", "cp_drive lead", cp_drive,
                force_z_n & (ref_first ? polarity : !polarity));
            chk("R9", "mon_o lead", mon_o,
                mon_sel ? (polarity ? ref_first : !ref_first) : exp_lock);
            repeat (n - 1) @(negedge clk);
            if (ref_first) cmp_pulse = 1'b1; else ref_pulse = 1'b1;
            @(negedge clk);
            ref_pulse = 1'b0; cmp_pulse = 1'b0;
        end
        chk("R4", "up_o overlap", up_o, 1'b1);
        chk("R4", "dn_o overlap", dn_o, 1'b1);
        chk("R4", "cp_en overlap", cp_en, 1'b0);
        @(negedge clk);
        chk("R4", "up_o released", up_o, 1'b0);
        chk("R4", "dn_o released", dn_o, 1'b0);
        repeat (3) @(negedge clk);
        model_cmp(n);
        chk((n >= UNLOCK) ? "R6" : "R7", $sformatf("lock_o after error %0d", n), lock_o, exp_lock);
        if (!mon_sel) chk("R9", "mon_o idle", mon_o, exp_lock);
    endtask

    // Power-down dip with a strobe that must be ignored (R8).
    task automatic power_dip();
        pwr_on = 1'b0;
        @(negedge clk);
        chk("R8", "lock_o in power-down", lock_o, 1'b1);
        ref_pulse = 1'b1;
        @(negedge clk);
        ref_pulse = 1'b0;
        chk("R8", "up_o in power-down", up_o, 1'b0);
        chk("R8", "dn_o in power-down", dn_o, 1'b0);
        chk("R8", "cp_en in power-down", cp_en, 1'b0);
        pwr_on = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8", "lock_o after wake", lock_o, 1'b1);
        chk("R8", "up_o strobe ignored", up_o, 1'b0);
        chk("R8", "dn_o strobe ignored", dn_o, 1'b0);
        exp_lock = 1'b1;
        exp_runs = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; ref_pulse = 1'b0; cmp_pulse = 1'b0; polarity = 1'b1;
        force_z_n = 1'b1; pwr_on = 1'b1; mon_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "lock_o reset", lock_o, 1'b0);
        chk("R1", "up_o reset", up_o, 1'b0);
        chk("R1", "dn_o reset", dn_o, 1'b0);
        chk("R1", "cp_en reset", cp_en, 1'b0);
        chk("R1", "cp_drive reset", cp_drive, 1'b0);
        chk("R1", "mon_o reset", mon_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        run_cmp(1'b1, 2);           // R7: first good comparison
        run_cmp(1'b1, 5);           // R7: second good, still unlocked
        run_cmp(1'b0, 7);           // R7: third good at boundary, lock rises
        run_cmp(1'b1, 0);           // R4: simultaneous strobes
        run_cmp(1'b0, 8);           // R6: error at threshold drops lock
        polarity = 1'b0;
        run_cmp(1'b0, 3);           // R3
        run_cmp(1'b1, 4);           // R3
        polarity = 1'b1;
        force_z_n = 1'b0;
        run_cmp(1'b1, 3);           // R5
        force_z_n = 1'b1;
        mon_sel = 1'b1;
        run_cmp(1'b1, 1);           // R9
        polarity = 1'b0;
        run_cmp(1'b0, 2);           // R9
        polarity = 1'b1;
        mon_sel = 1'b0;
        power_dip();                // R8
        run_cmp(1'b1, 3);           // R8: lock stays high after wake
        run_cmp(1'b0, 12);          // R6: large error

        for (int i = 0; i < 250; i++) begin
            polarity  = 1'($urandom_range(0, 1));
            force_z_n = ($urandom_range(0, 4) != 0);
            mon_sel   = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 19) == 0) power_dip();
            run_cmp(1'($urandom_range(0, 1)), $urandom_range(0, 12));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule